// File: doc/BRIEF.md
# Configuration Address/Data Port Translator

This block sits on the host side of an I/O bus. It turns processor port reads and writes into configuration-space transactions for a downstream fabric. A 32-bit address register at the base port holds an enable flag, a bus number, a device/function number and a register offset. The offset reaches 4 KiB per function because four extended offset bits sit in otherwise unused high bits. The dword four bytes above the base is a data window. An access there, with the enable flag set, becomes one downstream configuration read or write. The processor's byte enables are passed through unchanged, so the port byte within the window picks the lane.

The mechanism must first be selected with a byte write of 0x01 to the top byte of the base dword. Until it is selected, the address register and the window stay silent. Software detects the mechanism by writing 0x80000000 as a full dword and reading it back. It restores the old contents by writing them again. The processor holds its request until a one-cycle ready pulse. A downstream transaction that is aborted returns all ones, as does a window access that is not forwarded.

Top module: `cfg_port_xlat`

## Requirements
- R1: After a synchronous reset, `cpu_rdy` and `cfg_req` are low. The address register is zero and the mechanism is deselected.
- R2: A partial write that includes byte lane 3 of the base dword selects the mechanism when byte 3 of the data is 0x01, and deselects it for any other value. A partial read that includes lane 3 returns 0x01 (selected) or 0x00 (deselected) in bits 31:24, with ones in bits 23:0.
- R3: While deselected, full-dword writes to the base dword are ignored and reads of it return 0xFFFFFFFF. Window accesses are not forwarded.
- R4: While selected, a full-dword write to the base dword stores all 32 bits, and a full-dword read returns them unchanged.
- R5: A forwarded window access issues `cfg_req` with the following fields taken from the address register: `cfg_bus` = bits 23:16, `cfg_devfn` = bits 15:8, and `cfg_reg` = {bits 27:24, bits 7:2}, a dword index within 4 KiB. `cfg_wr` and `cfg_wdata` are copied from the processor access.
- R6: `cfg_be` equals the processor byte enables, so the byte at window port +n uses lane n, a 16-bit access uses lanes 1:0 or 3:2, and a dword access uses all four lanes.
- R7: With address bit 31 (enable) clear, a window access is not forwarded. A read returns 0xFFFFFFFF, and a write changes nothing.
- R8: `cfg_req` and its fields hold steady until `cfg_ack`. `cpu_rdy` pulses one cycle after the ack is sampled. A read then returns `cfg_rdata`.
- R9: A read acked with `cfg_abort` high returns 0xFFFFFFFF.
- R10: An access that is not forwarded completes with a one-cycle `cpu_rdy` pulse one cycle after the request is sampled, and no `cfg_req` is raised.
- R11: Partial accesses to the base dword that leave lane 3 clear, and accesses to any other port dword, change nothing and read 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_rdy` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_port_dw | input | PORT_W-2 | Port address, dword index (byte address bits PORT_W-1:2) |
| cpu_be | input | 4 | Byte enables; bit n = port byte +n |
| cpu_wdata | input | 32 | Write data, lane-positioned |
| cpu_rdy | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_rdy` |
| cfg_req | output | 1 | Downstream configuration request |
| cfg_wr | output | 1 | Downstream write flag |
| cfg_bus | output | 8 | Bus number |
| cfg_devfn | output | 8 | Device/function number |
| cfg_reg | output | 10 | Dword register index within 4 KiB |
| cfg_be | output | 4 | Downstream byte enables |
| cfg_wdata | output | 32 | Downstream write data |
| cfg_ack | input | 1 | Downstream completion, one cycle |
| cfg_abort | input | 1 | Completion had no responder |
| cfg_rdata | input | 32 | Downstream read data, valid with `cfg_ack` |

## Verification
Local accesses to the base dword, to the select byte or to an unused port finish exactly one cycle after the request is sampled. A forwarded window access finishes 2+L cycles after the request, where L is the target's added ack latency. The bench counts clock cycles from raising the request to seeing `cpu_rdy`, sampling on the falling edge, and compares that count with 1 or 2+L for every access. The forwarded fields are captured by the bench's target model in the cycle it acks, and read data is compared in the cycle `cpu_rdy` is seen. Both are compared with values the bench computes from the address it wrote.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_HOLD} xlat_st_e;
  typedef enum logic [1:0] {HIT_NONE, HIT_ADDR, HIT_SEL, HIT_WIN} hit_e;

  localparam int DATA_W  = 32;
  localparam int BE_W    = DATA_W / 8;
  localparam int BUS_W   = 8;
  localparam int DEVFN_W = 8;
  localparam int XREG_W  = 4;
  localparam int DREG_W  = 6;
  localparam int REG_W   = XREG_W + DREG_W;

  // Field positions inside the address register
  localparam int EN_BIT   = 31;
  localparam int XREG_LSB = 24;
  localparam int BUS_LSB  = 16;
  localparam int DEVFN_LSB = 8;
  localparam int DREG_LSB = 2;

  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [7:0] SEL_CODE = 8'h01;
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfg_port_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8
) (
  input  logic [PORT_W-3:0] port_dw,
  input  logic [BE_W-1:0]   be,
  output hit_e              hit
);
  localparam logic [PORT_W-3:0] ADDR_DW = ADDR_PORT[PORT_W-1:2];
  localparam logic [PORT_W-3:0] DATA_DW = ADDR_DW + 1'b1;

  always_comb begin
    hit = HIT_NONE;
    if (be != '0) begin
      if (port_dw == ADDR_DW) begin
        if (be == {BE_W{1'b1}})  hit = HIT_ADDR;
        else if (be[BE_W-1])     hit = HIT_SEL;
      end else if (port_dw == DATA_DW) begin
        hit = HIT_WIN;
      end
    end
  end
endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_addr,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] addr_q,
  output logic              sel_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      if (wr_addr) addr_q <= wdata;
      if (wr_sel)  sel_q  <= (wdata[DATA_W-1 -: 8] == SEL_CODE);
    end
  end
endmodule

// File: rtl/cfg_fwd_ctrl.sv
module cfg_fwd_ctrl
  import cfg_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_req,
  input  logic               cpu_wr,
  input  logic [BE_W-1:0]    cpu_be,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  hit_e               hit,
  input  logic [DATA_W-1:0]  addr_q,
  input  logic               sel_q,
  output logic               wr_addr,
  output logic               wr_sel,
  output logic               cpu_rdy,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               cfg_req,
  output logic               cfg_wr,
  output logic [BUS_W-1:0]   cfg_bus,
  output logic [DEVFN_W-1:0] cfg_devfn,
  output logic [REG_W-1:0]   cfg_reg,
  output logic [BE_W-1:0]    cfg_be,
  output logic [DATA_W-1:0]  cfg_wdata,
  input  logic               cfg_ack,
  input  logic               cfg_abort,
  input  logic [DATA_W-1:0]  cfg_rdata
);
  xlat_st_e          st;
  logic              take;
  logic              fwd;
  logic [DATA_W-1:0] loc_rd;

  assign take    = (st == ST_IDLE) && cpu_req;
  assign fwd     = (hit == HIT_WIN) && sel_q && addr_q[EN_BIT];
  assign wr_addr = take && cpu_wr && (hit == HIT_ADDR) && sel_q;
  assign wr_sel  = take && cpu_wr && (hit == HIT_SEL);

  always_comb begin
    case (hit)
      HIT_ADDR: loc_rd = sel_q ? addr_q : ALL_ONES;
      HIT_SEL:  loc_rd = {7'b0, sel_q, ALL_ONES[DATA_W-9:0]};
      default:  loc_rd = ALL_ONES;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cpu_rdy   <= 1'b0;
      cpu_rdata <= ALL_ONES;
      cfg_req   <= 1'b0;
      cfg_wr    <= 1'b0;
      cfg_bus   <= '0;
      cfg_devfn <= '0;
      cfg_reg   <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          cpu_rdy <= 1'b0;
          if (cpu_req) begin
            if (fwd) begin
              cfg_req   <= 1'b1;
              cfg_wr    <= cpu_wr;
              cfg_bus   <= addr_q[BUS_LSB +: BUS_W];
              cfg_devfn <= addr_q[DEVFN_LSB +: DEVFN_W];
              cfg_reg   <= {addr_q[XREG_LSB +: XREG_W], addr_q[DREG_LSB +: DREG_W]};
              cfg_be    <= cpu_be;
              cfg_wdata <= cpu_wdata;
              st        <= ST_BUSY;
            end else begin
              cpu_rdy   <= 1'b1;
              cpu_rdata <= cpu_wr ? ALL_ONES : loc_rd;
              st        <= ST_HOLD;
            end
          end
        end
        ST_BUSY: begin
          if (cfg_ack) begin
            cfg_req   <= 1'b0;
            cpu_rdy   <= 1'b1;
            cpu_rdata <= (cfg_wr || cfg_abort) ? ALL_ONES : cfg_rdata;
            st        <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          cpu_rdy <= 1'b0;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_port_xlat.sv
module cfg_port_xlat
  import cfg_port_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_req,
  input  logic               cpu_wr,
  input  logic [PORT_W-3:0]  cpu_port_dw,
  input  logic [BE_W-1:0]    cpu_be,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic               cpu_rdy,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               cfg_req,
  output logic               cfg_wr,
  output logic [BUS_W-1:0]   cfg_bus,
  output logic [DEVFN_W-1:0] cfg_devfn,
  output logic [REG_W-1:0]   cfg_reg,
  output logic [BE_W-1:0]    cfg_be,
  output logic [DATA_W-1:0]  cfg_wdata,
  input  logic               cfg_ack,
  input  logic               cfg_abort,
  input  logic [DATA_W-1:0]  cfg_rdata
);
  hit_e              hit;
  logic              wr_addr;
  logic              wr_sel;
  logic [DATA_W-1:0] addr_q;
  logic              sel_q;

  cfg_port_decode #(.PORT_W(PORT_W), .ADDR_PORT(ADDR_PORT)) u_dec (
    .port_dw (cpu_port_dw),
    .be      (cpu_be),
    .hit     (hit)
  );

  cfg_addr_reg u_areg (
    .clk     (clk),
    .rst     (rst),
    .wr_addr (wr_addr),
    .wr_sel  (wr_sel),
    .wdata   (cpu_wdata),
    .addr_q  (addr_q),
    .sel_q   (sel_q)
  );

  cfg_fwd_ctrl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_wr    (cpu_wr),
    .cpu_be    (cpu_be),
    .cpu_wdata (cpu_wdata),
    .hit       (hit),
    .addr_q    (addr_q),
    .sel_q     (sel_q),
    .wr_addr   (wr_addr),
    .wr_sel    (wr_sel),
    .cpu_rdy   (cpu_rdy),
    .cpu_rdata (cpu_rdata),
    .cfg_req   (cfg_req),
    .cfg_wr    (cfg_wr),
    .cfg_bus   (cfg_bus),
    .cfg_devfn (cfg_devfn),
    .cfg_reg   (cfg_reg),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_ack   (cfg_ack),
    .cfg_abort (cfg_abort),
    .cfg_rdata (cfg_rdata)
  );
endmodule

// File: rtl/cfg_port_xlat_chk.sv
module cfg_port_xlat_chk
  import cfg_port_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               cpu_rdy,
  input logic [DATA_W-1:0]  cpu_rdata,
  input logic               cfg_req,
  input logic               cfg_wr,
  input logic [BUS_W-1:0]   cfg_bus,
  input logic [DEVFN_W-1:0] cfg_devfn,
  input logic [REG_W-1:0]   cfg_reg,
  input logic [BE_W-1:0]    cfg_be,
  input logic               cfg_ack,
  input logic               cfg_abort,
  input logic [DATA_W-1:0]  addr_q,
  input logic               sel_q
);
  // R1
  rst_idle_chk: assert property (@(posedge clk) rst |=> (!cpu_rdy && !cfg_req));

  // R10
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rdy |=> !cpu_rdy);

  // R10
  rdy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rdy |-> !cfg_req);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_bus) && $stable(cfg_devfn)
                               && $stable(cfg_reg) && $stable(cfg_be) && $stable(cfg_wr)));

  // R8
  ack_done_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && cfg_ack) |=> (!cfg_req && cpu_rdy));

  // R7
  fwd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req) |-> (addr_q[EN_BIT] && sel_q));

  // R9
  abort_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && cfg_ack && cfg_abort && !cfg_wr) |=> (cpu_rdata == ALL_ONES));
endmodule

bind cfg_port_xlat cfg_port_xlat_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_rdy   (cpu_rdy),
  .cpu_rdata (cpu_rdata),
  .cfg_req   (cfg_req),
  .cfg_wr    (cfg_wr),
  .cfg_bus   (cfg_bus),
  .cfg_devfn (cfg_devfn),
  .cfg_reg   (cfg_reg),
  .cfg_be    (cfg_be),
  .cfg_ack   (cfg_ack),
  .cfg_abort (cfg_abort),
  .addr_q    (addr_q),
  .sel_q     (sel_q)
);

// File: tb/cfg_port_xlat_bench.sv
module cfg_port_xlat_bench;
  localparam logic [13:0] A_DW = 14'h33E;
  localparam logic [13:0] W_DW = 14'h33F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [13:0] cpu_port_dw = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rdy;
  logic [31:0] cpu_rdata;
  logic        cfg_req, cfg_wr;
  logic [7:0]  cfg_bus, cfg_devfn;
  logic [9:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_ack = 1'b0;
  logic        cfg_abort = 1'b0;
  logic [31:0] cfg_rdata = '0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int tgt_lat = 0;
  int wait_cnt = 0;
  int n_req = 0;
  logic [7:0]  t_bus, t_devfn;
  logic [9:0]  t_reg;
  logic [3:0]  t_be;
  logic        t_wr;
  logic [31:0] t_wdata;

  always #5 clk = ~clk;

  cfg_port_xlat u_cfg_port_xlat (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
    .cpu_port_dw(cpu_port_dw), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata), .cfg_req(cfg_req), .cfg_wr(cfg_wr),
    .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn), .cfg_reg(cfg_reg), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_abort(cfg_abort), .cfg_rdata(cfg_rdata)
  );

  function automatic logic [31:0] tdat(logic [7:0] b, logic [7:0] d, logic [9:0] r);
    return {b, d ^ 8'hA5, 6'h15, r};
  endfunction

  // Target model: acks tgt_lat cycles after seeing a request; bus 0xEE aborts
  initial begin
    forever begin
      @(negedge clk);
      if (cfg_ack) begin
        cfg_ack = 1'b0;
        cfg_abort = 1'b0;
      end else if (cfg_req) begin
        if (wait_cnt >= tgt_lat) begin
          wait_cnt  = 0;
          cfg_ack   = 1'b1;
          cfg_abort = (cfg_bus == 8'hEE);
          cfg_rdata = tdat(cfg_bus, cfg_devfn, cfg_reg);
          t_bus = cfg_bus; t_devfn = cfg_devfn; t_reg = cfg_reg;
          t_be = cfg_be; t_wr = cfg_wr; t_wdata = cfg_wdata;
          n_req++;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic io(input logic [13:0] pdw, input logic [3:0] be, input logic wr,
                    input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_port_dw = pdw; cpu_be = be; cpu_wr = wr; cpu_wdata = wd; cpu_req = 1'b1;
    cyc = 0;
    while (cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (cpu_rdy) break;
    end
    rd = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  function automatic logic [3:0] be_of(int b);
    case (b)
      0: return 4'h1;
      1: return 4'h2;
      2: return 4'h4;
      3: return 4'h8;
      4: return 4'h3;
      5: return 4'hC;
      default: return 4'hF;
    endcase
  endfunction

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc;
    int nb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cpu_rdy", {31'b0, cpu_rdy}, 32'h0);
    chk("R1 cfg_req", {31'b0, cfg_req}, 32'h0);

    // R3 deselected: base dword reads ones, writes ignored
    io(A_DW, 4'hF, 1'b1, 32'h8000_0000, rd, cyc);
    io(A_DW, 4'hF, 1'b0, 32'h0, rd, cyc);
    chk("R3 base read deselected", rd, 32'hFFFF_FFFF);
    chk("R10 local latency", cyc, 1);
    // R2 select byte reads 0x00 while deselected
    io(A_DW, 4'h8, 1'b0, 32'h0, rd, cyc);
    chk("R2 sel read off", rd, 32'h00FF_FFFF);
    io(A_DW, 4'h8, 1'b1, 32'h0200_0000, rd, cyc);
    io(A_DW, 4'h8, 1'b0, 32'h0, rd, cyc);
    chk("R2 sel code 02 ignored", rd, 32'h00FF_FFFF);
    io(A_DW, 4'h8, 1'b1, 32'h0100_0000, rd, cyc);
    io(A_DW, 4'hC, 1'b0, 32'h0, rd, cyc);
    chk("R2 sel read on", rd, 32'h01FF_FFFF);
    // R1 register was zero after reset (the R3 write was dropped)
    io(A_DW, 4'hF, 1'b0, 32'h0, rd, cyc);
    chk("R1 addr reg reset", rd, 32'h0);

    // R4 detection readback and restore patterns
    foreach (rd[i]) if (i < 0) rd = 0;
    for (int p = 0; p < 4; p++) begin
      logic [31:0] pat;
      pat = (p == 0) ? 32'h8000_0000 : (p == 1) ? 32'h7FFF_FFFF :
            (p == 2) ? 32'h5A5A_A5A7 : 32'h0;
      io(A_DW, 4'hF, 1'b1, pat, rd, cyc);
      chk("R10 write latency", cyc, 1);
      io(A_DW, 4'hF, 1'b0, 32'h0, rd, cyc);
      chk("R4 readback", rd, pat);
    end

    // R11 partial access without lane 3 ignored; other ports read ones
    io(A_DW, 4'hF, 1'b1, 32'h8012_3400, rd, cyc);
    io(A_DW, 4'h3, 1'b1, 32'h0000_FFFF, rd, cyc);
    chk("R11 partial read", rd, 32'hFFFF_FFFF);
    io(A_DW, 4'h7, 1'b0, 32'h0, rd, cyc);
    chk("R11 partial low read", rd, 32'hFFFF_FFFF);
    io(A_DW, 4'hF, 1'b0, 32'h0, rd, cyc);
    chk("R11 addr kept", rd, 32'h8012_3400);
    nb = n_req;
    io(14'h33D, 4'hF, 1'b0, 32'h0, rd, cyc);
    chk("R11 other port", rd, 32'hFFFF_FFFF);
    chk("R11 no fwd", n_req, nb);

    // R5 R6 R8 sweep of addresses, lanes, directions, latencies
    for (int a = 0; a < 8; a++) begin
      logic [7:0]  bus, dvf;
      logic [11:0] off;
      logic [31:0] av;
      bus = 8'(a * 37 + 1);
      dvf = 8'(a * 29 + 3);
      off = 12'((a * 523) & 12'hFFC);
      av  = 32'h8000_0000 | {4'h0, off[11:8], bus, dvf, off[7:2], 2'b00};
      tgt_lat = a % 4;
      io(A_DW, 4'hF, 1'b1, av, rd, cyc);
      for (int b = 0; b < 7; b++) begin
        for (int w = 0; w < 2; w++) begin
          logic [31:0] wd;
          wd = 32'(a * 32'h01010101 + b * 32'h00110011 + w);
          nb = n_req;
          io(W_DW, be_of(b), w[0], wd, rd, cyc);
          chk("R8 fwd latency", cyc, 2 + tgt_lat);
          chk("R5 one request", n_req, nb + 1);
          chk("R5 bus", {24'b0, t_bus}, {24'b0, bus});
          chk("R5 devfn", {24'b0, t_devfn}, {24'b0, dvf});
          chk("R5 reg", {22'b0, t_reg}, {22'b0, off[11:2]});
          chk("R6 lanes", {28'b0, t_be}, {28'b0, be_of(b)});
          chk("R5 dir", {31'b0, t_wr}, {31'b0, w[0]});
          if (w == 1) chk("R5 wdata", t_wdata, wd);
          else        chk("R8 rdata", rd, tdat(bus, dvf, off[11:2]));
        end
      end
    end

    // R9 abort returns ones
    tgt_lat = 1;
    io(A_DW, 4'hF, 1'b1, 32'h80EE_0810, rd, cyc);
    io(W_DW, 4'hF, 1'b0, 32'h0, rd, cyc);
    chk("R9 abort read", rd, 32'hFFFF_FFFF);
    chk("R9 abort latency", cyc, 3);

    // R7 enable clear: not forwarded
    io(A_DW, 4'hF, 1'b1, 32'h0012_3404, rd, cyc);
    nb = n_req;
    io(W_DW, 4'h1, 1'b0, 32'h0, rd, cyc);
    chk("R7 read ones", rd, 32'hFFFF_FFFF);
    chk("R7 read latency", cyc, 1);
    io(W_DW, 4'hF, 1'b1, 32'hDEAD_BEEF, rd, cyc);
    chk("R7 no request", n_req, nb);
    io(A_DW, 4'hF, 1'b0, 32'h0, rd, cyc);
    chk("R7 addr unchanged", rd, 32'h0012_3404);

    // R3 enable set but deselected: window not forwarded
    io(A_DW, 4'hF, 1'b1, 32'h8012_3404, rd, cyc);
    io(A_DW, 4'h8, 1'b1, 32'h0000_0000, rd, cyc);
    nb = n_req;
    io(W_DW, 4'hF, 1'b0, 32'h0, rd, cyc);
    chk("R3 window ones", rd, 32'hFFFF_FFFF);
    chk("R3 window no fwd", n_req, nb);
    io(A_DW, 4'h8, 1'b1, 32'h0100_0000, rd, cyc);
    io(A_DW, 4'hF, 1'b0, 32'h0, rd, cyc);
    chk("R2 reselect keeps addr", rd, 32'h8012_3404);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule